// File: doc/BRIEF.md
# Shared-Butterfly Row-Column 4x4 Transform

This block computes a two-dimensional transform of a 4x4 block of signed samples by the row-column method. A bank of four 1-D butterfly units, one per row, is used twice: in the first cycle it transforms the rows of the incoming block. The result is written transposed into a single transpose register. In the second cycle the same four units transform the rows of that register, which are the columns of the original block. The register contents are fed back into whichever kernel the column pass needs, so the row pass and the column pass may use different kernels.

Each butterfly unit is one shift-and-add datapath whose operand selection turns it into one of three integer kernels. The odd-part kernel of the 8x8 integer transform is one of them; its rows are 12,10,6,3 / 10,-3,-12,-6 / 6,-12,3,10 / 3,-6,10,-12, with an implied division by 8. The others are the 4x4 forward core transform and the 4x4 inverse core transform. Mixed modes apply the odd kernel along one dimension and the forward core along the other. This covers the odd-odd and odd-even quarters of an 8x8 transform. The plain modes give a second independent 4x4 path beside another core. A block is accepted every second cycle, and 16 coefficients leave with each result.

The controller has two states. ST_READY is idle and also carries the row pass of a block whose start is seen. ST_COLPASS carries the column pass. ST_READY moves to ST_COLPASS when start is sampled high. ST_COLPASS always returns to ST_READY on the next edge.

Top module: `xf4_rowcol`

## Requirements
- R1: After reset, dout_valid is low and every dout element is zero.
- R2: When start is sampled high at clock edge n in the ready state, dout_valid is high for exactly the one cycle after edge n+1. The result appears on dout at edge n+1, and dout holds its value at every other edge.
- R3: A start seen in the cycle after an accepted start is ignored, and so are the din and mode values of that cycle. The result of the accepted block is unaffected, and no further dout_valid pulse or dout change follows.
- R4: Blocks may be started on every second edge back to back, and each one produces its own correct result.
- R5: Element (r,c) of din and of dout sits at slice index 4*r+c, with widths IN_W and OUT_W. The result is Y = B*X*A^T followed by an arithmetic right shift by s, where A is the row-pass kernel and B the column-pass kernel.
- R6: Mode 3'b011 is the forward core: A = B = [1 1 1 1; 2 1 -1 -2; 1 -1 -1 1; 1 -2 2 -1], with s = 0.
- R7: Mode 3'b100 is the inverse core: A = B = [2 2 2 1; 2 1 -2 -2; 2 -1 -2 2; 2 -2 2 -1], with s = 2.
- R8: Mode 3'b000 is odd/odd: A = B = the odd kernel [12 10 6 3; 10 -3 -12 -6; 6 -12 3 10; 3 -6 10 -12], with s = 3.
- R9: Mode 3'b001 is odd/core: A is the odd kernel and B is the forward core, with s = 3.
- R10: Mode 3'b010 is core/odd: A is the forward core and B is the odd kernel, with s = 3.
- R11: Modes 3'b101, 3'b110 and 3'b111 return the input sign-extended to OUT_W, unchanged.
- R12: No intermediate value overflows for any input within IN_W bits, including all-maximum and all-minimum blocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a block; sampled only in the ready state |
| mode | input | 3 | Kernel pairing for the block, sampled with start |
| din | input | 16*IN_W | Sixteen signed input samples, element (r,c) at index 4*r+c |
| dout | output | 16*OUT_W | Sixteen signed results, same layout |
| dout_valid | output | 1 | One-cycle pulse marking a new result on dout |

## Verification
The hardest situation to reach from the ports is a start that arrives while the column pass is running. It must leave the transpose register, the latched mode and the output untouched. The stimulus raises start again in the column cycle, with different data and a different mode. It then checks that the first block's result is still correct and that no second valid pulse follows. Mixed modes are the other hard case, because an error in the cross-feedback path only shows when the row and column kernels differ. Impulses at all sixteen positions are swept in every mode, which isolates each kernel entry along each dimension.

// File: rtl/xf_pkg.sv
package xf_pkg;

    // kernel selector for one butterfly pass
    typedef enum logic [1:0] {
        KN_PASS = 2'd0,
        KN_CF   = 2'd1,
        KN_CI   = 2'd2,
        KN_ODD  = 2'd3
    } kern_e;

    localparam logic [2:0] MD_ODD_ODD  = 3'b000;
    localparam logic [2:0] MD_ODD_CORE = 3'b001;
    localparam logic [2:0] MD_CORE_ODD = 3'b010;
    localparam logic [2:0] MD_CORE_FWD = 3'b011;
    localparam logic [2:0] MD_CORE_INV = 3'b100;

    function automatic kern_e row_kern(input logic [2:0] m);
        kern_e k;
        unique case (m)
            MD_ODD_ODD:  k = KN_ODD;
            MD_ODD_CORE: k = KN_ODD;
            MD_CORE_ODD: k = KN_CF;
            MD_CORE_FWD: k = KN_CF;
            MD_CORE_INV: k = KN_CI;
            default:     k = KN_PASS;
        endcase
        return k;
    endfunction

    function automatic kern_e col_kern(input logic [2:0] m);
        kern_e k;
        unique case (m)
            MD_ODD_ODD:  k = KN_ODD;
            MD_ODD_CORE: k = KN_CF;
            MD_CORE_ODD: k = KN_ODD;
            MD_CORE_FWD: k = KN_CF;
            MD_CORE_INV: k = KN_CI;
            default:     k = KN_PASS;
        endcase
        return k;
    endfunction

    function automatic logic [1:0] out_shift(input logic [2:0] m);
        logic [1:0] s;
        unique case (m)
            MD_ODD_ODD, MD_ODD_CORE, MD_CORE_ODD: s = 2'd3;
            MD_CORE_INV:                          s = 2'd2;
            default:                              s = 2'd0;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/xf_bfly.sv
module xf_bfly
    import xf_pkg::*;
#(
    parameter int W = 22
) (
    input  kern_e              kern,
    input  logic signed [W-1:0] x [0:3],
    output logic signed [W-1:0] y [0:3]
);

    // shift-and-add constant products
    function automatic logic signed [W-1:0] m3(input logic signed [W-1:0] v);
        return (v <<< 1) + v;
    endfunction
    function automatic logic signed [W-1:0] m6(input logic signed [W-1:0] v);
        return (v <<< 2) + (v <<< 1);
    endfunction
    function automatic logic signed [W-1:0] m10(input logic signed [W-1:0] v);
        return (v <<< 3) + (v <<< 1);
    endfunction
    function automatic logic signed [W-1:0] m12(input logic signed [W-1:0] v);
        return (v <<< 3) + (v <<< 2);
    endfunction

    logic signed [W-1:0] sa, sb, da, db;
    logic signed [W-1:0] ea, eb, oa, ob;

    always_comb begin
        // forward core butterfly terms
        sa = x[0] + x[3];
        sb = x[1] + x[2];
        da = x[0] - x[3];
        db = x[1] - x[2];
        // inverse core butterfly terms (scaled by 2)
        ea = (x[0] + x[2]) <<< 1;
        eb = (x[0] - x[2]) <<< 1;
        oa = (x[1] <<< 1) + x[3];
        ob = x[1] - (x[3] <<< 1);
        unique case (kern)
            KN_CF: begin
                y[0] = sa + sb;
                y[1] = (da <<< 1) + db;
                y[2] = sa - sb;
                y[3] = da - (db <<< 1);
            end
            KN_CI: begin
                y[0] = ea + oa;
                y[1] = eb + ob;
                y[2] = eb - ob;
                y[3] = ea - oa;
            end
            KN_ODD: begin
                y[0] = m12(x[0]) + m10(x[1]) + m6(x[2])  + m3(x[3]);
                y[1] = m10(x[0]) - m3(x[1])  - m12(x[2]) - m6(x[3]);
                y[2] = m6(x[0])  - m12(x[1]) + m3(x[2])  + m10(x[3]);
                y[3] = m3(x[0])  - m6(x[1])  + m10(x[2]) - m12(x[3]);
            end
            default: begin
                y[0] = x[0];
                y[1] = x[1];
                y[2] = x[2];
                y[3] = x[3];
            end
        endcase
    end

    // forward core: even outputs sum to twice the outer pair (R6)
    always_comb begin
        if (kern == KN_CF)
            assert_core_dc_R6: assert ((y[0] + y[2]) == ((x[0] + x[3]) <<< 1));
    end

endmodule

// File: rtl/xf_ctrl.sv
module xf_ctrl
    import xf_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic [2:0] mode,
    output logic       accept,
    output logic       col_phase,
    output kern_e      kern,
    output logic [1:0] shift_q
);

    typedef enum logic {
        ST_READY   = 1'b0,
        ST_COLPASS = 1'b1
    } state_e;

    state_e     state_q, state_d;
    logic [2:0] mode_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_READY;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_READY:   if (start) state_d = ST_COLPASS;
            ST_COLPASS: state_d = ST_READY;
            default:    state_d = ST_READY;
        endcase
    end

    // latched block settings
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q  <= 3'b111;
            shift_q <= 2'd0;
        end else if (accept) begin
            mode_q  <= mode;
            shift_q <= out_shift(mode);
        end
    end

    // outputs
    always_comb begin
        accept    = 1'b0;
        col_phase = 1'b0;
        kern      = KN_PASS;
        unique case (state_q)
            ST_READY: begin
                accept = start;
                kern   = row_kern(mode);
            end
            ST_COLPASS: begin
                col_phase = 1'b1;
                kern      = col_kern(mode_q);
            end
            default: ;
        endcase
    end

    assert_mode_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
        col_phase |=> $stable(mode_q));

    assert_one_accept_R4: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> !accept);

endmodule

// File: rtl/xf4_rowcol.sv
module xf4_rowcol
    import xf_pkg::*;
#(
    parameter int IN_W = 12
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic [2:0]           mode,
    input  logic [16*IN_W-1:0]   din,
    output logic [16*(IN_W+10)-1:0] dout,
    output logic                 dout_valid
);

    localparam int N     = 4;
    localparam int GROW  = 5;              // per-pass magnitude growth bits
    localparam int ACC_W = IN_W + 2*GROW;
    localparam int OUT_W = ACC_W;
    localparam int EXT   = ACC_W - IN_W;

    logic       accept, col_phase;
    kern_e      kern;
    logic [1:0] shift_q;

    xf_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .mode      (mode),
        .accept    (accept),
        .col_phase (col_phase),
        .kern      (kern),
        .shift_q   (shift_q)
    );

    logic signed [ACC_W-1:0] tr_q [0:N-1][0:N-1];
    logic signed [ACC_W-1:0] opnd [0:N-1][0:N-1];
    logic signed [ACC_W-1:0] res  [0:N-1][0:N-1];

    // operand select: fresh input rows or the fed-back transposed rows
    for (genvar r = 0; r < N; r++) begin : g_row
        for (genvar c = 0; c < N; c++) begin : g_col
            logic [IN_W-1:0] raw;
            assign raw = din[(r*N+c)*IN_W +: IN_W];
            assign opnd[r][c] = col_phase ? tr_q[r][c]
                                          : $signed({{EXT{raw[IN_W-1]}}, raw});
        end
        xf_bfly #(.W(ACC_W)) u_bfly (
            .kern (kern),
            .x    (opnd[r]),
            .y    (res[r])
        );
    end

    // transpose register written by the row pass
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int r = 0; r < N; r++)
                for (int c = 0; c < N; c++)
                    tr_q[r][c] <= '0;
        end else if (accept) begin
            for (int r = 0; r < N; r++)
                for (int c = 0; c < N; c++)
                    tr_q[c][r] <= res[r][c];
        end
    end

    // output register written by the column pass, transposed back
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dout       <= '0;
            dout_valid <= 1'b0;
        end else begin
            dout_valid <= col_phase;
            if (col_phase) begin
                for (int r = 0; r < N; r++)
                    for (int c = 0; c < N; c++)
                        dout[(r*N+c)*OUT_W +: OUT_W] <= res[c][r] >>> shift_q;
            end
        end
    end

    assert_col_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> col_phase);

    assert_valid_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
        col_phase |=> dout_valid);

    assert_valid_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        dout_valid |=> !dout_valid);

    assert_dout_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !col_phase |=> $stable(dout));

endmodule

// File: tb/sim_xf4_rowcol.sv
module sim_xf4_rowcol;

    localparam int IN_W  = 12;
    localparam int OUT_W = IN_W + 10;

    logic                   clk = 1'b0;
    logic                   rst_n = 1'b0;
    logic                   start = 1'b0;
    logic [2:0]             mode = 3'd0;
    logic [16*IN_W-1:0]     din = '0;
    logic [16*OUT_W-1:0]    dout;
    logic                   dout_valid;

    int checks = 0;
    int errors = 0;
    bit finished = 0;
    int unsigned seed = 32'h1234_5678;

    always #5 clk = ~clk;

    xf4_rowcol #(.IN_W(IN_W)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .mode(mode),
        .din(din), .dout(dout), .dout_valid(dout_valid)
    );

    localparam int KCF [16] = '{1,1,1,1, 2,1,-1,-2, 1,-1,-1,1, 1,-2,2,-1};
    localparam int KCI [16] = '{2,2,2,1, 2,1,-2,-2, 2,-1,-2,2, 2,-2,2,-1};
    localparam int KOD [16] = '{12,10,6,3, 10,-3,-12,-6, 6,-12,3,10, 3,-6,10,-12};

    // kind: 0 pass, 1 fwd core, 2 inv core, 3 odd
    function automatic longint kv(int kind, int i, int j);
        case (kind)
            1: return longint'(KCF[i*4+j]);
            2: return longint'(KCI[i*4+j]);
            3: return longint'(KOD[i*4+j]);
            default: return (i == j) ? 64'sd1 : 64'sd0;
        endcase
    endfunction

    function automatic string req_of(int m);
        case (m)
            0: return "R8";
            1: return "R9";
            2: return "R10";
            3: return "R6";
            4: return "R7";
            default: return "R11";
        endcase
    endfunction

    longint xin [16];
    longint expv [16];

    // Y = B*X*A^T >>> s   (R5)
    task automatic compute(input int m);
        int ka, kb, s;
        case (m)
            0: begin ka = 3; kb = 3; s = 3; end
            1: begin ka = 3; kb = 1; s = 3; end
            2: begin ka = 1; kb = 3; s = 3; end
            3: begin ka = 1; kb = 1; s = 0; end
            4: begin ka = 2; kb = 2; s = 2; end
            default: begin ka = 0; kb = 0; s = 0; end
        endcase
        for (int r = 0; r < 4; r++)
            for (int c = 0; c < 4; c++) begin
                longint acc = 0;
                for (int i = 0; i < 4; i++)
                    for (int j = 0; j < 4; j++)
                        acc += kv(kb, r, i) * xin[i*4+j] * kv(ka, c, j);
                expv[r*4+c] = acc >>> s;
            end
    endtask

    function automatic longint dget(int idx);
        return longint'($signed(dout[idx*OUT_W +: OUT_W]));
    endfunction

    task automatic drive_block(input int m);
        mode = m[2:0];
        for (int i = 0; i < 16; i++) din[i*IN_W +: IN_W] = xin[i][IN_W-1:0];
        start = 1'b1;
    endtask

    task automatic check_data(input string tag);
        int bad = -1;
        checks++;
        for (int i = 0; i < 16; i++)
            if (bad < 0 && dget(i) != expv[i]) bad = i;
        if (bad >= 0) begin
            errors++;
            $display("FAIL %s element %0d actual=%0d expected=%0d",
                     tag, bad, dget(bad), expv[bad]);
        end
    endtask

    task automatic check_bit(input string tag, input logic act, input logic ex);
        checks++;
        if (act !== ex) begin
            errors++;
            $display("FAIL %s dout_valid actual=%0b expected=%0b", tag, act, ex);
        end
    endtask

    // one block, called at a negedge; returns at the negedge after edge n+1
    task automatic run_block(input int m);
        compute(m);
        drive_block(m);
        @(negedge clk);
        start = 1'b0;
        check_bit("R2 mid", dout_valid, 1'b0);
        @(negedge clk);
        check_bit("R2 out", dout_valid, 1'b1);
        check_data(req_of(m));
    endtask

    function automatic longint rnd();
        seed = seed * 32'd1103515245 + 32'd12345;
        return longint'((seed >> 16) & 32'hFFF) - 2048;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        longint keep [16];
        repeat (3) @(negedge clk);
        // R1 reset state
        check_bit("R1", dout_valid, 1'b0);
        checks++;
        if (dout !== '0) begin
            errors++;
            $display("FAIL R1 dout actual=%0h expected=0", dout);
        end
        rst_n = 1'b1;
        @(negedge clk);

        // impulse sweep over all modes and positions
        for (int m = 0; m < 8; m++)
            for (int p = 0; p < 16; p++) begin
                for (int i = 0; i < 16; i++) xin[i] = 0;
                xin[p] = (p % 2) ? -777 : 1000;
                run_block(m);
            end

        // pseudo-random blocks, back to back (R4)
        for (int m = 0; m < 8; m++)
            for (int k = 0; k < 12; k++) begin
                for (int i = 0; i < 16; i++) xin[i] = rnd();
                run_block(m);
            end

        // extremes (R12)
        for (int m = 0; m < 8; m++) begin
            for (int i = 0; i < 16; i++) xin[i] = 2047;
            run_block(m);
            for (int i = 0; i < 16; i++) xin[i] = -2048;
            run_block(m);
            for (int i = 0; i < 16; i++) xin[i] = ((i + i/4) % 2) ? -2048 : 2047;
            run_block(m);
        end

        // R3: start with other data and mode during the column cycle
        for (int i = 0; i < 16; i++) xin[i] = rnd();
        compute(0);
        drive_block(0);
        @(negedge clk);
        for (int i = 0; i < 16; i++) xin[i] = 5;
        drive_block(3);
        check_bit("R3 mid", dout_valid, 1'b0);
        @(negedge clk);
        start = 1'b0;
        check_bit("R3 out", dout_valid, 1'b1);
        check_data("R3");
        for (int i = 0; i < 16; i++) keep[i] = expv[i];
        @(negedge clk);
        check_bit("R3 no pulse", dout_valid, 1'b0);
        @(negedge clk);
        check_bit("R3 no pulse 2", dout_valid, 1'b0);
        for (int i = 0; i < 16; i++) expv[i] = keep[i];
        check_data("R3 hold");

        // R2 hold over idle cycles
        repeat (4) @(negedge clk);
        check_data("R2 hold");

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule